// File: doc/BRIEF.md
# Dual-Group Registered Bus Transceiver

This block links two bidirectional data ports, A and B, each modelled as an input vector, an output vector and a per-group output enable. The ports are divided into independent channel groups (two groups of 8 bits by default). Each group has its own isolate control, direction control, two capture clocks and two source selects. Either group may run alone, or all groups may be tied together to form one wide transceiver.

Each group holds two storage registers. One samples the A port on every rising edge of that group's A-capture clock. The other samples the B port on every rising edge of its B-capture clock. The driven port carries either the live value from the opposite port or the value held in the opposite-side register. The choice is a plain two-input multiplexer, so the output depends only on the select and the two data sources and has no decode hazard. At most one side of a group is driven at a time. Storage continues whatever the state of the output controls.

Top module: `regbus_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab[g]` with `rst` low, the group-g A-side register loads `a_in[g*GW +: GW]`.
- R2: On every rising edge of `clk_ba[g]` with `rst` low, the group-g B-side register loads `b_in[g*GW +: GW]`.
- R3: Capture is unaffected by `iso`, `dir_ab`, `sel_ab` and `sel_ba`. Values loaded while a group is isolated or driving can later be seen through the stored-data path.
- R4: When `iso[g]` is 1, `a_oe[g]` and `b_oe[g]` are both 0.
- R5: When `iso[g]` is 0 and `dir_ab[g]` is 0, `a_oe[g]`=1 and `b_oe[g]`=0. The group-g slice of `a_out` is the live `b_in` slice when `sel_ba[g]`=0, and the stored B-side register when `sel_ba[g]`=1.
- R6: When `iso[g]` is 0 and `dir_ab[g]` is 1, `b_oe[g]`=1 and `a_oe[g]`=0. The group-g slice of `b_out` is the live `a_in` slice when `sel_ab[g]`=0, and the stored A-side register when `sel_ab[g]`=1.
- R7: `a_oe[g]` and `b_oe[g]` are never 1 at the same time.
- R8: A group's outputs and registers depend only on its own controls, its own clocks and its own bit slice. Clocking or switching one group leaves every other group unchanged.
- R9: A rising capture-clock edge with the synchronous active-high `rst` at 1 clears that register to zero. After reset, a stored-data transfer yields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled on each capture clock |
| clk_ab | input | GROUPS | Per-group capture clock for the A-side register |
| clk_ba | input | GROUPS | Per-group capture clock for the B-side register |
| iso | input | GROUPS | Per-group isolate: 1 drives neither port |
| dir_ab | input | GROUPS | Per-group direction: 1 drives B from A, 0 drives A from B |
| sel_ab | input | GROUPS | Per-group B-port source: 0 live A, 1 stored A |
| sel_ba | input | GROUPS | Per-group A-port source: 0 live B, 1 stored B |
| a_in | input | GROUPS*GW | A port input value |
| b_in | input | GROUPS*GW | B port input value |
| a_out | output | GROUPS*GW | Value to drive onto the A port |
| a_oe | output | GROUPS | Per-group A port drive enable |
| b_out | output | GROUPS*GW | Value to drive onto the B port |
| b_oe | output | GROUPS | Per-group B port drive enable |

## Verification
The bench runs all sixteen isolate/direction/select combinations. Each combination is run once with identical controls on both groups and once with the controls of group 1 inverted, so that a crossed group wiring shows up. Live and stored sources are given different data, so a swapped select polarity or a swapped register is detected. Captures are made while a group is isolated and while it drives the other way, to show that storage never pauses. A capture on one group's clock is followed by a check that the other group's stored value is unchanged. A reset edge applied on one clock only is followed by a check that only that register returns to zero.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DEF_GROUPS = 2;
    localparam int DEF_GW     = 8;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
    } drive_t;

    function automatic drive_t decode_drive(input logic isolate, input logic to_b);
        drive_t d;
        d.a_en = !isolate && !to_b;
        d.b_en = !isolate &&  to_b;
        return d;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assert_load_every_edge_R1_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(d)));

    assert_clear_R9: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  src_e         src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    always_comb begin
        case (src)
            SRC_STORED: y = stored;
            default:    y = live;
        endcase
    end
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group
    import xcvr_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          rst,
    input  logic          clk_ab,
    input  logic          clk_ba,
    input  logic          iso,
    input  logic          dir_ab,
    input  logic          sel_ab,
    input  logic          sel_ba,
    input  logic [GW-1:0] a_in,
    input  logic [GW-1:0] b_in,
    output logic [GW-1:0] a_out,
    output logic          a_oe,
    output logic [GW-1:0] b_out,
    output logic          b_oe
);
    logic [GW-1:0] held_a;
    logic [GW-1:0] held_b;
    drive_t        drv;

    xcvr_store_reg #(.W(GW)) u_hold_a (.clk(clk_ab), .rst(rst), .d(a_in), .q(held_a));
    xcvr_store_reg #(.W(GW)) u_hold_b (.clk(clk_ba), .rst(rst), .d(b_in), .q(held_b));

    xcvr_path_mux #(.W(GW)) u_to_a (
        .src(src_e'(sel_ba)), .live(b_in), .stored(held_b), .y(a_out));
    xcvr_path_mux #(.W(GW)) u_to_b (
        .src(src_e'(sel_ab)), .live(a_in), .stored(held_a), .y(b_out));

    always_comb drv = decode_drive(iso, dir_ab);
    assign a_oe = drv.a_en;
    assign b_oe = drv.b_en;

    assert_oe_exclusive_R7: assert property (@(posedge clk_ab) disable iff (rst)
        !(a_oe && b_oe));
    assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (rst)
        iso |-> (!a_oe && !b_oe));
    assert_b_source_R6: assert property (@(posedge clk_ab) disable iff (rst)
        b_oe |-> (b_out == (sel_ab ? held_a : a_in)));
    assert_a_source_R5: assert property (@(posedge clk_ba) disable iff (rst)
        a_oe |-> (a_out == (sel_ba ? held_b : b_in)));
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int GROUPS = DEF_GROUPS,
    parameter int GW     = DEF_GW
) (
    input  logic                 rst,
    input  logic [GROUPS-1:0]    clk_ab,
    input  logic [GROUPS-1:0]    clk_ba,
    input  logic [GROUPS-1:0]    iso,
    input  logic [GROUPS-1:0]    dir_ab,
    input  logic [GROUPS-1:0]    sel_ab,
    input  logic [GROUPS-1:0]    sel_ba,
    input  logic [GROUPS*GW-1:0] a_in,
    input  logic [GROUPS*GW-1:0] b_in,
    output logic [GROUPS*GW-1:0] a_out,
    output logic [GROUPS-1:0]    a_oe,
    output logic [GROUPS*GW-1:0] b_out,
    output logic [GROUPS-1:0]    b_oe
);
    localparam int W = GROUPS * GW;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        xcvr_group #(.GW(GW)) u_grp (
            .rst    (rst),
            .clk_ab (clk_ab[g]),
            .clk_ba (clk_ba[g]),
            .iso    (iso[g]),
            .dir_ab (dir_ab[g]),
            .sel_ab (sel_ab[g]),
            .sel_ba (sel_ba[g]),
            .a_in   (a_in[g*GW +: GW]),
            .b_in   (b_in[g*GW +: GW]),
            .a_out  (a_out[g*GW +: GW]),
            .a_oe   (a_oe[g]),
            .b_out  (b_out[g*GW +: GW]),
            .b_oe   (b_oe[g])
        );
    end

    if (W < 1) begin : g_bad_width
        initial $error("regbus_xcvr: total width must be positive");
    end
endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
    localparam int G  = 2;
    localparam int GW = 8;
    localparam int W  = G * GW;

    typedef struct {
        logic [W-1:0] a_out;
        logic [G-1:0] a_oe;
        logic [W-1:0] b_out;
        logic [G-1:0] b_oe;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst = 1'b1;
    logic [G-1:0] cen_ab = '0, cen_ba = '0;
    logic [G-1:0] iso = '1, dir_ab = '0, sel_ab = '0, sel_ba = '0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [G-1:0] clk_ab, clk_ba;
    logic [W-1:0] a_out, b_out;
    logic [G-1:0] a_oe, b_oe;

    assign clk_ab = {G{clk}} & cen_ab;
    assign clk_ba = {G{clk}} & cen_ba;

    regbus_xcvr #(.GROUPS(G), .GW(GW)) u_regbus_xcvr (
        .rst(rst), .clk_ab(clk_ab), .clk_ba(clk_ba), .iso(iso), .dir_ab(dir_ab),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

    int checks = 0, errors = 0;
    logic [GW-1:0] m_a [G];
    logic [GW-1:0] m_b [G];
    exp_t q[$];

    task automatic expect_now(input string tag);
        exp_t e;
        for (int g = 0; g < G; g++) begin
            e.a_oe[g] = !iso[g] && !dir_ab[g];
            e.b_oe[g] = !iso[g] &&  dir_ab[g];
            e.a_out[g*GW +: GW] = sel_ba[g] ? m_b[g] : b_in[g*GW +: GW];
            e.b_out[g*GW +: GW] = sel_ab[g] ? m_a[g] : a_in[g*GW +: GW];
        end
        e.tag = tag;
        @(negedge clk);
        q.push_back(e);
        wait (q.size() == 0);
        #1;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (q.size() != 0);
            #1;
            e = q.pop_front();
            checks++;
            if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
                errors++;
                $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b, expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                         e.tag, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
            end
            checks++;
            if ((a_oe & b_oe) != '0) begin
                errors++;
                $display("FAIL R7: got a_oe=%b b_oe=%b, expected no common bit", a_oe, b_oe);
            end
        end
    end

    task automatic pulse(input bit side_b, input int g);
        @(negedge clk);
        if (side_b) cen_ba[g] = 1'b1; else cen_ab[g] = 1'b1;
        @(negedge clk);
        if (side_b) begin
            cen_ba[g] = 1'b0;
            m_b[g] = rst ? '0 : b_in[g*GW +: GW];
        end else begin
            cen_ab[g] = 1'b0;
            m_a[g] = rst ? '0 : a_in[g*GW +: GW];
        end
    endtask

    function automatic string tag_of(input logic i, input logic d);
        if (i) return "R4";
        return d ? "R6" : "R5";
    endfunction

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        for (int g = 0; g < G; g++) begin m_a[g] = 'x; m_b[g] = 'x; end
        // R9: reset on every capture clock
        @(negedge clk);
        cen_ab = '1; cen_ba = '1;
        repeat (3) @(negedge clk);
        cen_ab = '0; cen_ba = '0;
        rst = 1'b0;
        for (int g = 0; g < G; g++) begin m_a[g] = '0; m_b[g] = '0; end
        iso = '0; dir_ab = '1; sel_ab = '1; a_in = 16'hA5C3;
        expect_now("R9 stored A after reset");
        dir_ab = '0; sel_ba = '1; b_in = 16'h3C5A;
        expect_now("R9 stored B after reset");

        // R1 R2: load both sides of both groups
        a_in = 16'h1234; b_in = 16'h9ABC;
        for (int g = 0; g < G; g++) begin pulse(1'b0, g); pulse(1'b1, g); end
        a_in = 16'h0F0F; b_in = 16'hF0F0;
        dir_ab = '1; sel_ab = '1;
        expect_now("R1 stored A drives B");
        dir_ab = '0; sel_ba = '1;
        expect_now("R2 stored B drives A");

        // R4 R5 R6 R8: every control combination, shared and inverted group 1
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 2; v++) begin
                logic [3:0] k0, k1;
                k0 = c[3:0];
                k1 = v ? ~c[3:0] : c[3:0];
                iso    = {k1[3], k0[3]};
                dir_ab = {k1[2], k0[2]};
                sel_ab = {k1[1], k0[1]};
                sel_ba = {k1[0], k0[0]};
                a_in = 16'h1111 * (c + 1) ^ {8'h00, 8'(v * 8'h5A)};
                b_in = ~a_in ^ 16'h6006;
                expect_now($sformatf("%s/%s combo %0d inv %0d R8",
                           tag_of(iso[0], dir_ab[0]), tag_of(iso[1], dir_ab[1]), c, v));
            end
        end

        // R3: capture while isolated and while driving the other way
        iso = '1; a_in = 16'h7E81; b_in = 16'h2442;
        pulse(1'b0, 0); pulse(1'b1, 1);
        iso = '0; dir_ab = 2'b10; sel_ab = '1; sel_ba = '1;
        a_in = 16'h5555; b_in = 16'hAAAA;
        pulse(1'b1, 0);
        a_in = 16'h0000; b_in = 16'hFFFF;
        dir_ab = 2'b01;
        expect_now("R3 stored after isolated capture");
        dir_ab = 2'b10;
        expect_now("R3 stored after capture while driving");

        // R8: one group's clock leaves the other group's register alone
        a_in = 16'hC3D4;
        pulse(1'b0, 1);
        a_in = 16'h0101; dir_ab = '1;
        expect_now("R8 only group 1 A reloaded");

        // R9: reset seen by one capture clock only
        rst = 1'b1;
        pulse(1'b1, 1);
        rst = 1'b0;
        dir_ab = '0; sel_ba = '1;
        expect_now("R9 group 1 B cleared, group 0 B kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule